// File: doc/BRIEF.md
# Glitch-free selectable clock divider

The block takes one symmetrical clock and produces one output clock at the input rate, or at half, a quarter or an eighth of it. A 2-bit rate select picks the rate. All divided rates come from one free-running 3-bit counter. The select may change at any time and with no relation to the clock, so it first passes through a two-stage synchronizer.

A new rate is only taken up when the counter wraps from its all-ones value to zero. At that instant every divided clock starts a new period. The output therefore never shows a runt pulse or a shortened high or low phase, whichever way the rate moves.

At the full rate, the output is the input clock gated by an enable. That enable is only updated on the falling edge, so it can never change while the clock is high. Before a switch away from the full rate, the enable closes on the falling edge ahead of the wrap.

Top module: `glitchfree_clk_div`

## Requirements
- R1: While the active-high synchronous reset is held, the output clock stays low.
- R2: Select code 00 gives an output equal to the input clock: one half input period high, then one half period low.
- R3: Select code 01 gives the input divided by 2: high and low phases of one input period each.
- R4: Select code 10 gives the input divided by 4: high and low phases of two input periods each.
- R5: Select code 11 gives the input divided by 8: high and low phases of four input periods each. All divided rates come from one counter that advances by one on every rising input edge outside reset.
- R6: The active rate changes only on the rising edge where the counter returns to zero. No output phase seen during a switch is shorter than the shorter half period of the old and new rates.
- R7: The select passes through two flip-flops before use. A change is not visible on the output during the first two input cycles, and it is in effect within ten input cycles.
- R8: The full-rate gate enable is closed on every rising edge at which a divided rate is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Symmetrical source clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rate_sel_i | input | 2 | Asynchronous rate select: 00 /1, 01 /2, 10 /4, 11 /8 |
| clk_o | output | 1 | Selected output clock |

## Verification
The hardest case to reach is the exact edge where a freshly synchronized select meets the counter wrap. This matters most when the full-rate gate must close on the falling edge just before that wrap. The stimulus walks a table of rate transitions that covers every direction, including the jumps between divide by 1 and divide by 8. It drives each select change a few nanoseconds after a clock edge, so the select lands at varied counter phases. It records the length of every high and low run of the output in half-period samples. A separate directed case pins down both the earliest and the latest point at which a change may take effect. Another case resets the block in mid-period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int SEL_W       = 2;
    localparam int CNT_W       = (1 << SEL_W) - 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [SEL_W-1:0] {
        RATE_FULL   = 2'd0,
        RATE_HALF   = 2'd1,
        RATE_QUART  = 2'd2,
        RATE_EIGHTH = 2'd3
    } rate_e;

    typedef logic [CNT_W-1:0] cnt_t;

    // Divided clock level for a given count and rate; full rate has no tap.
    function automatic logic rate_tap(cnt_t c, rate_e r);
        logic v;
        v = 1'b0;
        for (int k = 1; k <= CNT_W; k++) begin
            if (int'(r) == k) v = c[k-1];
        end
        return v;
    endfunction

    function automatic logic is_last(cnt_t c);
        return &c;
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[0] <= '0;
                    else       stage_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '0;
                    else       stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output cnt_t cnt_o,
    output cnt_t cnt_next_o,
    output logic last_o
);
    cnt_t cnt_q;

    assign cnt_next_o = rst_i ? '0 : cnt_t'(cnt_q + 1'b1);
    assign last_o     = is_last(cnt_q);
    assign cnt_o      = cnt_q;

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_next_o;
    end
endmodule

// File: rtl/clkdiv_rate_reg.sv
module clkdiv_rate_reg
    import clkdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  last_i,
    input  rate_e sync_i,
    output rate_e active_o,
    output rate_e active_next_o
);
    rate_e active_q;

    always_comb begin
        if (rst_i)       active_next_o = RATE_FULL;
        else if (last_i) active_next_o = sync_i;
        else             active_next_o = active_q;
    end

    always_ff @(posedge clk_i) begin
        active_q <= active_next_o;
    end

    assign active_o = active_q;
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
    import clkdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  cnt_t  cnt_next_i,
    input  rate_e active_i,
    input  rate_e active_next_i,
    input  rate_e sync_i,
    input  logic  last_i,
    output logic  gate_en_o,
    output logic  clk_o
);
    logic div_q;
    logic en_q;
    logic keep_full;

    // Divided clock registered on the rising edge, from next-state values.
    always_ff @(posedge clk_i) begin
        if (rst_i) div_q <= 1'b0;
        else       div_q <= rate_tap(cnt_next_i, active_next_i);
    end

    // Full-rate gate: closes ahead of a wrap that leaves the full rate.
    assign keep_full = (active_i == RATE_FULL) &&
                       (!last_i || (sync_i == RATE_FULL));

    always_ff @(negedge clk_i) begin
        if (rst_i) en_q <= 1'b0;
        else       en_q <= keep_full;
    end

    assign gate_en_o = en_q;
    assign clk_o     = (clk_i & en_q) | div_q;
endmodule

// File: rtl/glitchfree_clk_div.sv
module glitchfree_clk_div
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    output logic             clk_o
);
    logic [SEL_W-1:0] sync_bits;
    rate_e            sync_sel;
    cnt_t             cnt_q;
    cnt_t             cnt_next;
    logic             cnt_last;
    rate_e            active_q;
    rate_e            active_next;
    logic             gate_en;

    clkdiv_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (rate_sel_i),
        .q_o   (sync_bits)
    );

    assign sync_sel = rate_e'(sync_bits);

    clkdiv_counter cnt_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_o      (cnt_q),
        .cnt_next_o (cnt_next),
        .last_o     (cnt_last)
    );

    clkdiv_rate_reg rate_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .last_i        (cnt_last),
        .sync_i        (sync_sel),
        .active_o      (active_q),
        .active_next_o (active_next)
    );

    clkdiv_out_stage out_i (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .cnt_next_i     (cnt_next),
        .active_i       (active_q),
        .active_next_i  (active_next),
        .sync_i         (sync_sel),
        .last_i         (cnt_last),
        .gate_en_o      (gate_en),
        .clk_o          (clk_o)
    );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
    import clkdiv_pkg::*;
(
    input logic  clk_i,
    input logic  rst_i,
    input logic  clk_o,
    input cnt_t  cnt_q,
    input rate_e active_q,
    input rate_e sync_sel,
    input logic  gate_en
);
    // R1
    out_low_in_reset_chk: assert property (@(negedge clk_i)
        (rst_i && $past(rst_i)) |-> !clk_o);

    // R5
    count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    // R6
    switch_at_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_q != $past(active_q)) |-> (cnt_q == '0));

    // R7
    sync_adopt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (&cnt_q) |=> (active_q == $past(sync_sel)));

    // R8
    gate_closed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_q != RATE_FULL) |-> !gate_en);
endmodule

bind glitchfree_clk_div clkdiv_chk chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clk_o    (clk_o),
    .cnt_q    (cnt_q),
    .active_q (active_q),
    .sync_sel (sync_sel),
    .gate_en  (gate_en)
);

// File: tb/glitchfree_clk_div_tb.sv
`timescale 1ns/1ps
module glitchfree_clk_div_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       clk_o;

    always #4 clk = ~clk;

    glitchfree_clk_div dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .rate_sel_i (sel),
        .clk_o      (clk_o)
    );

    int total = 0;
    int bad   = 0;

    // Run-length monitor: samples 2 ns after every clock edge.
    logic prev_s   = 1'b0;
    int   cur_len  = 0;
    int   last_len = 0;
    int   runs     = 0;
    int   min_run  = 1000;

    always begin
        @(clk);
        #2;
        if (clk_o === prev_s) begin
            cur_len++;
        end else begin
            last_len = cur_len;
            runs++;
            if (cur_len < min_run) min_run = cur_len;
            cur_len = 1;
            prev_s  = clk_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_runs(input int n);
        int r0;
        r0 = runs;
        wait (runs >= r0 + n);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Stimulus table: select code, expected half-period count, requirement.
    localparam int    N_VEC = 8;
    localparam int    SEL_SEQ [N_VEC] = '{1, 2, 3, 0, 3, 1, 2, 0};
    localparam int    HALF_EXP[N_VEC] = '{2, 4, 8, 1, 8, 2, 4, 1};
    localparam string REQ_TAG [N_VEC] = '{"R3", "R4", "R5", "R2", "R5", "R3", "R4", "R2"};

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int old_half;

        // R1: output low while reset is held
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(clk);
            #2;
            check(clk_o == 1'b0, "R1 reset low", int'(clk_o), 0);
        end

        @(posedge clk);
        #3 rst = 1'b0;
        repeat (20) @(posedge clk);

        // R2: full rate straight after reset
        wait_runs(1);
        wait_runs(1);
        check(last_len == 1, "R2 full rate", last_len, 1);

        old_half = 1;
        for (int i = 0; i < N_VEC; i++) begin
            @(posedge clk);
            #3 sel = 2'(SEL_SEQ[i]);
            min_run = 1000;
            repeat (30) @(posedge clk);
            // R6: no phase shorter than the shorter of the two half periods
            check(min_run >= ((old_half < HALF_EXP[i]) ? old_half : HALF_EXP[i]),
                  "R6 switch", min_run,
                  (old_half < HALF_EXP[i]) ? old_half : HALF_EXP[i]);
            wait_runs(1);
            wait_runs(1);
            check(last_len == HALF_EXP[i], REQ_TAG[i], last_len, HALF_EXP[i]);
            wait_runs(1);
            check(last_len == HALF_EXP[i], REQ_TAG[i], last_len, HALF_EXP[i]);
            old_half = HALF_EXP[i];
        end

        // R7: change not visible for two cycles, in effect within ten
        @(posedge clk);
        #1 sel = 2'b11;
        @(posedge clk); #2;
        check(clk_o == 1'b1, "R7 early high", int'(clk_o), 1);
        @(negedge clk); #2;
        check(clk_o == 1'b0, "R7 early low", int'(clk_o), 0);
        @(posedge clk); #2;
        check(clk_o == 1'b1, "R7 early high2", int'(clk_o), 1);
        repeat (9) @(posedge clk);
        min_run = 1000;
        begin
            int r0;
            r0 = runs;
            repeat (20) @(posedge clk);
            check(runs - r0 >= 2, "R7 runs seen", runs - r0, 2);
        end
        check(min_run >= 8, "R7 latency", min_run, 8);

        // R1: reset in mid-period at divide by 8
        @(posedge clk);
        #3 rst = 1'b1;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(clk);
            #2;
            check(clk_o == 1'b0, "R1 mid reset low", int'(clk_o), 0);
        end
        @(posedge clk);
        #3 rst = 1'b0;
        repeat (30) @(posedge clk);
        wait_runs(1);
        wait_runs(1);
        check(last_len == 8, "R5 after reset", last_len, 8);

        finish_up();
    end

endmodule